// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits between a UART receiver and its receive FIFO. Each accepted character is compared with four programmable flow-control characters: a resume and a pause character for pair A, and a resume and a pause character for pair B. A two-bit compare mode selects which pair, if any, takes part in software flow control. Characters that belong to the active pair are consumed by flow control and are not written into the FIFO. Every other character is passed to the FIFO write port.

Independently of flow control, a special-character detector can be turned on. When on, it flags any received character equal to the pair-B pause character.

Both the special-character flag and the pause-detect flag are sticky until the host reads status. A shared interrupt-enable bit gates the two flags onto a single registered interrupt request. With pair B selected, one pause-B character is swallowed and raises both causes at once. With pair A selected, the same character is stored and raises only the special cause.

Top module: `rx_special_match`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fifo_wr`, `spec_flag`, `xoff_flag` and `irq` are 0.
- R2: A character presented with `rx_valid` high at a rising edge produces, if stored, `fifo_wr`=1 for exactly the following cycle with `fifo_data` equal to that character. Back-to-back strobes give back-to-back writes.
- R3: With `spec_en`=0, `spec_flag` never sets, whatever characters arrive.
- R4: With `spec_en`=1, a character whose 8 bits all equal `pause_chr_b` (bit 0 of the register against the character's LSB) sets `spec_flag` on the following cycle. A bit-reversed value does not match. Outside compare mode 2'b01 the character is still stored.
- R5: In compare mode 2'b10, characters equal to `resume_chr_a` or `pause_chr_a` are not stored. `pause_chr_a` sets `xoff_flag`. A `pause_chr_b` match is stored and sets `spec_flag` when `spec_en`=1.
- R6: In compare mode 2'b01, characters equal to `resume_chr_b` or `pause_chr_b` are not stored. `pause_chr_b` sets `xoff_flag`, and also `spec_flag` when `spec_en`=1.
- R7: In compare modes 2'b00 and 2'b11, no character is consumed, and `xoff_flag` never sets.
- R8: Both flags stay set until a `stat_clr` pulse. A `stat_clr` sampled on the same edge as a matching strobe wins, and both flags read 0 afterwards.
- R9: `irq` is registered and equals `spec_irq_en` AND (`spec_flag` OR `xoff_flag`), using the enable and the flag values committed at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | DATA_W | Received character |
| spec_en | input | 1 | Special-character detect enable |
| cmp_mode | input | 2 | 00 none, 10 pair A, 01 pair B, 11 none |
| resume_chr_a | input | DATA_W | Pair-A resume character |
| pause_chr_a | input | DATA_W | Pair-A pause character |
| resume_chr_b | input | DATA_W | Pair-B resume character |
| pause_chr_b | input | DATA_W | Pair-B pause character, also the special character |
| spec_irq_en | input | 1 | Interrupt enable for the flag causes |
| stat_clr | input | 1 | Status-read clear pulse |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | DATA_W | Receive FIFO write data |
| spec_flag | output | 1 | Special character seen (sticky) |
| xoff_flag | output | 1 | Pause character seen (sticky) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are a status clear landing on the very edge that commits a new match, and one pause-B character raising both causes while it is withheld from the FIFO. The stimulus reaches the first by driving `stat_clr` and `rx_valid` together on one cycle with a matching character. It reaches the second by selecting mode 2'b01 with detection and interrupts enabled before sending pause-B. Bit-reversed and back-to-back characters probe the compare order and the one-cycle write timing.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;

  typedef enum logic [1:0] {
    CMP_NONE  = 2'b00,
    CMP_PAIRB = 2'b01,
    CMP_PAIRA = 2'b10,
    CMP_RSVD  = 2'b11
  } cmp_mode_e;

  localparam int N_CHARS      = 4;
  localparam int IDX_RESUME_A = 0;
  localparam int IDX_PAUSE_A  = 1;
  localparam int IDX_RESUME_B = 2;
  localparam int IDX_PAUSE_B  = 3;

  typedef struct packed {
    logic drop;
    logic xoff_hit;
    logic spec_hit;
  } verdict_t;

endpackage

// File: rtl/rxsc_char_match.sv
module rxsc_char_match #(
  parameter int DATA_W = 8,
  parameter int N      = 4
) (
  input  logic [DATA_W-1:0]        data,
  input  logic [N-1:0][DATA_W-1:0] refs,
  output logic [N-1:0]             hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (data == refs[i]);
  end
endmodule

// File: rtl/rxsc_classify.sv
module rxsc_classify
  import rxsc_pkg::*;
#(
  parameter int N = N_CHARS
) (
  input  logic [N-1:0] hit,
  input  cmp_mode_e    mode,
  input  logic         spec_en,
  output verdict_t     verdict
);
  always_comb begin
    verdict = '0;
    unique case (mode)
      CMP_PAIRA: begin
        verdict.drop     = hit[IDX_RESUME_A] | hit[IDX_PAUSE_A];
        verdict.xoff_hit = hit[IDX_PAUSE_A];
      end
      CMP_PAIRB: begin
        verdict.drop     = hit[IDX_RESUME_B] | hit[IDX_PAUSE_B];
        verdict.xoff_hit = hit[IDX_PAUSE_B];
      end
      default: begin
        verdict.drop     = 1'b0;
        verdict.xoff_hit = 1'b0;
      end
    endcase
    verdict.spec_hit = spec_en & hit[IDX_PAUSE_B];
  end
endmodule

// File: rtl/rxsc_status.sv
module rxsc_status
  import rxsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  verdict_t          verdict,
  input  logic              clr,
  input  logic              irq_en,
  output logic              wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              spec_q,
  output logic              xoff_q,
  output logic              irq_q
);
  logic spec_nxt, xoff_nxt;

  // clear outranks a same-edge set
  always_comb begin
    spec_nxt = clr ? 1'b0 : (spec_q | (valid & verdict.spec_hit));
    xoff_nxt = clr ? 1'b0 : (xoff_q | (valid & verdict.xoff_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr      <= 1'b0;
      wr_data <= '0;
      spec_q  <= 1'b0;
      xoff_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      wr     <= valid & ~verdict.drop;
      if (valid) wr_data <= data;
      spec_q <= spec_nxt;
      xoff_q <= xoff_nxt;
      irq_q  <= irq_en & (spec_nxt | xoff_nxt);
    end
  end
endmodule

// File: rtl/rx_special_match.sv
module rx_special_match
  import rxsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              spec_en,
  input  logic [1:0]        cmp_mode,
  input  logic [DATA_W-1:0] resume_chr_a,
  input  logic [DATA_W-1:0] pause_chr_a,
  input  logic [DATA_W-1:0] resume_chr_b,
  input  logic [DATA_W-1:0] pause_chr_b,
  input  logic              spec_irq_en,
  input  logic              stat_clr,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              spec_flag,
  output logic              xoff_flag,
  output logic              irq
);
  logic [N_CHARS-1:0][DATA_W-1:0] refs;
  logic [N_CHARS-1:0]             hit;
  verdict_t                       verdict;

  always_comb begin
    refs[IDX_RESUME_A] = resume_chr_a;
    refs[IDX_PAUSE_A]  = pause_chr_a;
    refs[IDX_RESUME_B] = resume_chr_b;
    refs[IDX_PAUSE_B]  = pause_chr_b;
  end

  rxsc_char_match #(.DATA_W(DATA_W), .N(N_CHARS)) u_match (
    .data (rx_data),
    .refs (refs),
    .hit  (hit)
  );

  rxsc_classify #(.N(N_CHARS)) u_class (
    .hit     (hit),
    .mode    (cmp_mode_e'(cmp_mode)),
    .spec_en (spec_en),
    .verdict (verdict)
  );

  rxsc_status #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .valid   (rx_valid),
    .data    (rx_data),
    .verdict (verdict),
    .clr     (stat_clr),
    .irq_en  (spec_irq_en),
    .wr      (fifo_wr),
    .wr_data (fifo_data),
    .spec_q  (spec_flag),
    .xoff_q  (xoff_flag),
    .irq_q   (irq)
  );
endmodule

// File: rtl/rx_special_match_chk.sv
module rx_special_match_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              spec_en,
  input logic [1:0]        cmp_mode,
  input logic [DATA_W-1:0] pause_chr_b,
  input logic              spec_irq_en,
  input logic              stat_clr,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              spec_flag,
  input logic              xoff_flag,
  input logic              irq
);
  a_r2_wr_after_strobe: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(rx_valid));

  a_r2_wr_data: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (fifo_data == $past(rx_data)));

  a_r3_spec_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(spec_flag) |-> $past(spec_en && rx_valid && rx_data == pause_chr_b));

  a_r6_pause_b_dropped: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cmp_mode == 2'b01 && rx_data == pause_chr_b) |=> !fifo_wr);

  a_r6_pause_b_xoff: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !stat_clr && cmp_mode == 2'b01 && rx_data == pause_chr_b) |=> xoff_flag);

  a_r7_xoff_needs_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_flag) |-> $past(rx_valid && (cmp_mode == 2'b01 || cmp_mode == 2'b10)));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (!spec_flag && !xoff_flag));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (spec_flag && !stat_clr) |=> spec_flag);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !spec_irq_en |=> !irq);
endmodule

bind rx_special_match rx_special_match_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .spec_en     (spec_en),
  .cmp_mode    (cmp_mode),
  .pause_chr_b (pause_chr_b),
  .spec_irq_en (spec_irq_en),
  .stat_clr    (stat_clr),
  .fifo_wr     (fifo_wr),
  .fifo_data   (fifo_data),
  .spec_flag   (spec_flag),
  .xoff_flag   (xoff_flag),
  .irq         (irq)
);

// File: tb/rx_special_match_bench.sv
module rx_special_match_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       spec_en = 1'b0;
  logic [1:0] cmp_mode = 2'b00;
  logic [7:0] resume_chr_a = 8'h11;
  logic [7:0] pause_chr_a  = 8'h13;
  logic [7:0] resume_chr_b = 8'h21;
  logic [7:0] pause_chr_b  = 8'h1C;
  logic       spec_irq_en = 1'b0;
  logic       stat_clr = 1'b0;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic       spec_flag, xoff_flag, irq;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    started = 0;

  // reference model state
  bit       e_wr, e_spec, e_xoff, e_irq;
  bit [7:0] e_data;
  bit       m_drop, m_xoff, m_spec;

  always #5 clk = ~clk;

  rx_special_match u_rx_special_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .spec_en(spec_en), .cmp_mode(cmp_mode),
    .resume_chr_a(resume_chr_a), .pause_chr_a(pause_chr_a),
    .resume_chr_b(resume_chr_b), .pause_chr_b(pause_chr_b),
    .spec_irq_en(spec_irq_en), .stat_clr(stat_clr),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .spec_flag(spec_flag), .xoff_flag(xoff_flag), .irq(irq)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      e_wr = 0; e_spec = 0; e_xoff = 0; e_irq = 0; e_data = 0;
    end else begin
      m_drop = 0; m_xoff = 0; m_spec = 0;
      if (rx_valid) begin
        if (cmp_mode == 2'b10) begin
          if (rx_data == resume_chr_a) m_drop = 1;
          if (rx_data == pause_chr_a) begin m_drop = 1; m_xoff = 1; end
        end
        if (cmp_mode == 2'b01) begin
          if (rx_data == resume_chr_b) m_drop = 1;
          if (rx_data == pause_chr_b) begin m_drop = 1; m_xoff = 1; end
        end
        if (spec_en && rx_data == pause_chr_b) m_spec = 1;
        e_data = rx_data;
      end
      e_wr = rx_valid && !m_drop;
      if (stat_clr) begin
        e_spec = 0; e_xoff = 0;
      end else begin
        e_spec = e_spec || m_spec;
        e_xoff = e_xoff || m_xoff;
      end
      e_irq = spec_irq_en && (e_spec || e_xoff);
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("fifo_wr", {7'd0, fifo_wr}, {7'd0, e_wr});
      chk("spec_flag", {7'd0, spec_flag}, {7'd0, e_spec});
      chk("xoff_flag", {7'd0, xoff_flag}, {7'd0, e_xoff});
      chk("irq", {7'd0, irq}, {7'd0, e_irq});
      if (e_wr) chk("fifo_data", fifo_data, e_data);
    end
  end

  task automatic send(input logic [7:0] d, input bit clr_too);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; stat_clr = clr_too;
    @(negedge clk);
    rx_valid = 1'b0; stat_clr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(2);

    cur_req = "R2";
    send(8'h41, 0); send(8'h42, 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk); rx_data = 8'h5A;
    @(negedge clk); rx_data = 8'hFF;
    @(negedge clk); rx_valid = 1'b0;
    idle(2);

    cur_req = "R3";
    send(pause_chr_b, 0); send(8'h00, 0);
    idle(2);

    cur_req = "R4";
    spec_en = 1'b1;
    send(8'h38, 0);
    idle(1);
    send(pause_chr_b, 0);
    idle(3);
    clear_status();

    cur_req = "R9";
    send(pause_chr_b, 0);
    idle(2);
    @(negedge clk); spec_irq_en = 1'b1;
    idle(2);
    @(negedge clk); spec_irq_en = 1'b0;
    idle(2);
    clear_status();
    spec_irq_en = 1'b1;

    cur_req = "R5";
    cmp_mode = 2'b10;
    send(resume_chr_a, 0); send(8'h55, 0);
    send(pause_chr_a, 0); idle(1);
    clear_status();
    send(pause_chr_b, 0); send(resume_chr_b, 0);
    idle(2);
    clear_status();

    cur_req = "R6";
    cmp_mode = 2'b01;
    send(resume_chr_b, 0); send(pause_chr_b, 0);
    idle(2);
    clear_status();
    spec_en = 1'b0;
    send(pause_chr_b, 0); send(pause_chr_a, 0);
    idle(2);
    clear_status();
    spec_en = 1'b1;

    cur_req = "R7";
    cmp_mode = 2'b11;
    send(pause_chr_a, 0); send(resume_chr_a, 0); send(resume_chr_b, 0);
    send(pause_chr_b, 0);
    cmp_mode = 2'b00;
    send(pause_chr_a, 0);
    idle(2);
    clear_status();

    cur_req = "R8";
    cmp_mode = 2'b01;
    send(pause_chr_b, 1);
    idle(2);
    send(pause_chr_b, 0);
    idle(4);
    send(8'h77, 0);
    idle(2);
    clear_status();
    idle(2);

    summary();
  end
endmodule